// File: doc/BRIEF.md
# Stereo Soft Mute Ramp

This block fades a stereo stream of signed audio samples down to silence and back up again. A single request input selects the direction. While the request is high, the gain falls by one step on every sample frame until the output is exactly zero. While the request is low, the gain climbs by one step per frame until the samples pass through untouched. The gain can change direction at any step, and it moves at the same rate either way.

Each frame presents one left and one right 24-bit two's complement sample together with a one-cycle frame strobe. On that strobe the gain counter takes its step. Both samples are scaled by the new gain, and the results appear on registered outputs one clock later. A status flag reports when the fade has reached full silence. The block sits between a decimation stage and a serial output formatter. It lets the signal source be switched without an audible click and without stopping the stream.

Top module: `soft_mute_ramp`

## Requirements
- R1: A synchronous reset sets the gain to unity (1024), drives both sample outputs to zero and holds `muted` low.
- R2: On the clock edge where `frame_stb` is high, the gain takes its step. Each output is registered to trunc(sample × G / 1024), where G is the gain after that step. The result is visible from the next cycle.
- R3: While `mute_req` is high, each frame strobe lowers the gain by one, saturating at 0. Starting from unity, the 1024th frame outputs exactly zero on both channels, and later frames keep doing so.
- R4: While `mute_req` is low, each frame strobe raises the gain by one, saturating at 1024. At gain 1024 each output equals its input sample bit for bit.
- R5: If the request changes part-way through a ramp, the gain turns around at its current value and moves one step per frame in the new direction. After 300 frames down and 300 frames up it is back at unity.
- R6: Without a frame strobe, the gain and both outputs hold, whatever `mute_req` and the sample inputs do.
- R7: `muted` is high exactly while the gain is zero. It rises in the same cycle as the zero output of the frame that reaches zero.
- R8: Scaling rounds toward zero. For example, a sample of -1 at gain 1023 gives 0, not -1.
- R9: The left and right channels are scaled by the same gain and independently of each other's data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_stb | input | 1 | One-cycle strobe marking a new sample frame |
| mute_req | input | 1 | High: ramp toward silence; low: ramp toward unity |
| in_left | input | 24 | Left sample, two's complement |
| in_right | input | 24 | Right sample, two's complement |
| out_left | output | 24 | Scaled left sample, registered |
| out_right | output | 24 | Scaled right sample, registered |
| muted | output | 1 | High while the gain is zero |

## Verification
Every result is due on the first rising edge after the strobe. On that edge the gain register and the sample registers update together, and `muted` follows the gain register with no extra delay. The bench drives each frame on a falling edge, keeps the strobe high through exactly one rising edge, and compares the outputs on the next falling edge against a gain model it keeps itself. For the hold cases it waits several edges with the strobe low and checks that nothing moved. The reversal case uses a sample of 2^22, so the output equals 4096 × gain and the gain position can be read directly at the ports.

// File: rtl/smr_pkg.sv
package smr_pkg;
  parameter int unsigned SMR_DATA_W   = 24;
  parameter int unsigned SMR_RAMP_LEN = 1024;
  parameter int unsigned SMR_CHANNELS = 2;
  localparam int unsigned SMR_SHIFT   = $clog2(SMR_RAMP_LEN);
  localparam int unsigned SMR_GAIN_W  = SMR_SHIFT + 1;

  typedef logic [SMR_GAIN_W-1:0] gain_t;
endpackage

// File: rtl/smr_gain_ctr.sv
module smr_gain_ctr
  import smr_pkg::*;
#(
  parameter int unsigned RAMP_LEN = SMR_RAMP_LEN,
  localparam int unsigned GW = $clog2(RAMP_LEN) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stb,
  input  logic          req,
  output logic [GW-1:0] gain_nxt,
  output logic          muted
);
  localparam logic [GW-1:0] UNITY = GW'(RAMP_LEN);

  logic [GW-1:0] gain_q;
  logic          at_floor;
  logic          at_top;

  assign at_floor = (gain_q == '0);
  assign at_top   = (gain_q == UNITY);

  always_comb begin
    gain_nxt = gain_q;
    if (stb) begin
      if (req && !at_floor)      gain_nxt = gain_q - 1'b1;
      else if (!req && !at_top)  gain_nxt = gain_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) gain_q <= UNITY;
    else     gain_q <= gain_nxt;
  end

  assign muted = at_floor;

  AST_GAIN_RANGE: assert property (@(posedge clk) disable iff (rst)
    gain_q <= UNITY); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (stb && req && gain_q != '0) |=> gain_q == $past(gain_q) - 1'b1); // R3
  AST_FLOOR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stb && req && gain_q == '0) |=> gain_q == '0); // R3
  AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (stb && !req && gain_q != UNITY) |=> gain_q == $past(gain_q) + 1'b1); // R4
  AST_TOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stb && !req && gain_q == UNITY) |=> gain_q == UNITY); // R4
  AST_NO_STB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb |=> gain_q == $past(gain_q)); // R6
endmodule

// File: rtl/smr_scaler.sv
module smr_scaler
  import smr_pkg::*;
#(
  parameter int unsigned DATA_W   = SMR_DATA_W,
  parameter int unsigned RAMP_LEN = SMR_RAMP_LEN,
  localparam int unsigned SHIFT = $clog2(RAMP_LEN),
  localparam int unsigned GW    = SHIFT + 1,
  localparam int unsigned PW    = DATA_W + GW + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stb,
  input  logic [GW-1:0]            gain,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] dout
);
  localparam logic [GW-1:0] UNITY = GW'(RAMP_LEN);

  // sample * gain / RAMP_LEN, truncated toward zero
  function automatic logic signed [DATA_W-1:0] scale_trunc(
      input logic signed [DATA_W-1:0] s, input logic [GW-1:0] g);
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] quo;
    prod = PW'(s) * $signed({1'b0, g});
    if (prod < 0) prod = prod + PW'((1 << SHIFT) - 1);
    quo = prod >>> SHIFT;
    return quo[DATA_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      dout <= '0;
    else if (stb) dout <= scale_trunc(din, gain);
  end

  AST_ZERO_AT_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (stb && gain == '0) |=> dout == '0); // R3
  AST_UNITY_PASS: assert property (@(posedge clk) disable iff (rst)
    (stb && gain == UNITY) |=> dout == $past(din)); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(dout)); // R6
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (stb && din >= 0) |=> dout >= 0); // R8
endmodule

// File: rtl/soft_mute_ramp.sv
module soft_mute_ramp
  import smr_pkg::*;
#(
  parameter int unsigned DATA_W   = SMR_DATA_W,
  parameter int unsigned RAMP_LEN = SMR_RAMP_LEN,
  localparam int unsigned GW = $clog2(RAMP_LEN) + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frame_stb,
  input  logic                     mute_req,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right,
  output logic                     muted
);
  localparam int unsigned NCH = SMR_CHANNELS;

  logic [GW-1:0]            gain_nxt;
  logic signed [DATA_W-1:0] ch_in  [NCH];
  logic signed [DATA_W-1:0] ch_out [NCH];

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  smr_gain_ctr #(.RAMP_LEN(RAMP_LEN)) u_gain (
    .clk      (clk),
    .rst      (rst),
    .stb      (frame_stb),
    .req      (mute_req),
    .gain_nxt (gain_nxt),
    .muted    (muted)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    smr_scaler #(.DATA_W(DATA_W), .RAMP_LEN(RAMP_LEN)) u_scale (
      .clk  (clk),
      .rst  (rst),
      .stb  (frame_stb),
      .gain (gain_nxt),
      .din  (ch_in[c]),
      .dout (ch_out[c])
    );
  end

  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];

  AST_MUTED_SILENT: assert property (@(posedge clk) disable iff (rst)
    muted |-> (out_left == '0 && out_right == '0)); // R7
  AST_MUTED_ONLY_BY_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(muted) |-> $past(mute_req) && $past(frame_stb)); // R7
  AST_UNMUTE_ONLY_BY_REQ: assert property (@(posedge clk) disable iff (rst)
    $fell(muted) |-> !$past(mute_req) && $past(frame_stb)); // R5
endmodule

// File: tb/tb_soft_mute_ramp.sv
module tb_soft_mute_ramp;
  logic clk = 1'b0;
  logic rst;
  logic frame_stb;
  logic mute_req;
  logic signed [23:0] in_left, in_right;
  logic signed [23:0] out_left, out_right;
  logic muted;

  int checks = 0;
  int errors = 0;
  int g_exp  = 1024;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  soft_mute_ramp dut (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .mute_req(mute_req),
    .in_left(in_left), .in_right(in_right),
    .out_left(out_left), .out_right(out_right), .muted(muted)
  );

  // {mute_req, left, right}
  localparam logic [48:0] VEC [0:7] = '{
    {1'b0, 24'h123456, 24'hEDCBAA},   // unity pass-through R4 R9
    {1'b0, 24'h7FFFFF, 24'h800000},   // extremes at unity R4
    {1'b1, 24'hFFFFFF, 24'h800000},   // gain 1023: -1 -> 0  R8
    {1'b1, 24'hFFFC00, 24'h000400},   // gain 1022 R2
    {1'b1, 24'h000001, 24'hFFFFFE},   // gain 1021 R8
    {1'b0, 24'h400000, 24'hC00000},   // back up 1022 R5
    {1'b0, 24'h000000, 24'h7FFFFF},   // 1023 R9
    {1'b0, 24'hABCDEF, 24'h012345}    // 1024 R4
  };

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint model(input int s, input int g);
    return (longint'(s) * g) / 1024;   // division truncates toward zero
  endfunction

  task automatic frame(input int l, input int r, input bit req, input string tag);
    @(negedge clk);
    in_left = l[23:0]; in_right = r[23:0]; mute_req = req; frame_stb = 1'b1;
    @(negedge clk);
    frame_stb = 1'b0;
    if (req && g_exp > 0) g_exp--;
    else if (!req && g_exp < 1024) g_exp++;
    check({tag, " left"},  longint'(out_left),  model(l, g_exp));
    check({tag, " right"}, longint'(out_right), model(r, g_exp));
    check({tag, " R7 muted"}, longint'(muted), longint'(g_exp == 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int sl, sr;
    rst = 1'b1; frame_stb = 1'b0; mute_req = 1'b0;
    in_left = '0; in_right = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 out_left reset",  longint'(out_left),  0);
    check("R1 out_right reset", longint'(out_right), 0);
    check("R1 muted reset",     longint'(muted),     0);

    // vector table walk
    for (int i = 0; i < 8; i++) begin
      sl = int'($signed(VEC[i][47:24]));
      sr = int'($signed(VEC[i][23:0]));
      frame(sl, sr, VEC[i][48], "R2 vec");
    end

    // R6: no strobe, inputs and request wiggle, nothing moves
    @(negedge clk);
    in_left = 24'h000111; in_right = 24'hF00000; mute_req = 1'b1;
    repeat (6) @(negedge clk);
    check("R6 hold left",  longint'(out_left),  model(int'($signed(24'hABCDEF)), 1024));
    check("R6 hold right", longint'(out_right), model(32'h012345, 1024));
    check("R6 hold muted", longint'(muted), 0);
    frame(32'h00400000, -4194304, 1'b0, "R6 gain unmoved");

    // R5: reversal mid-ramp, gain read through sample 2^22
    for (int i = 0; i < 300; i++) frame(32'h00400000, 1000, 1'b1, "R5 down");
    check("R5 turn point", longint'(out_left), 4096 * 724);
    for (int i = 0; i < 300; i++) frame(32'h00400000, -1000, 1'b0, "R5 up");
    check("R5 back to unity", longint'(out_left), 4194304);

    // R3: full ramp to silence, then saturate
    for (int i = 0; i < 1024; i++) begin
      frame(8388607 - i * 13, -8388608 + i * 7, 1'b1, "R3 ramp");
      if (i == 1022) check("R3 not yet muted", longint'(muted), 0);
    end
    check("R3 zero left",  longint'(out_left),  0);
    check("R3 zero right", longint'(out_right), 0);
    check("R7 muted at floor", longint'(muted), 1);
    frame(8388607, -8388608, 1'b1, "R3 saturate");

    // R4: climb back, saturate at unity
    for (int i = 0; i < 1025; i++) frame(-5 * i - 1, 3 * i + 1, 1'b0, "R4 ramp");
    check("R4 pass-through", longint'(out_right), 3 * 1024 + 1);

    // R1: reset in mid-ramp
    for (int i = 0; i < 500; i++) frame(777, -777, 1'b1, "R1 pre");
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    g_exp = 1024;
    check("R1 mid reset left", longint'(out_left), 0);
    check("R1 mid reset muted", longint'(muted), 0);
    frame(-123457, 654321, 1'b0, "R1 unity after reset");

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule